// File: doc/BRIEF.md
# OFDM Subcarrier Mapper

This block turns coded data into one frequency-domain OFDM symbol for a 64-point inverse FFT. Each input transfer carries 48 data bits and a 2-bit rate code. The rate code selects a constellation. With BPSK one transfer fills a whole symbol. With QPSK two transfers fill a symbol, and with 16-QAM four transfers do. Every tone is a complex value in Q15 form, where a fraction in [-1, 1) is stored as the value times 32768. The real part is in the upper 16 bits of each 32-bit tone word and the imaginary part is in the lower 16 bits.

Output bin k holds subcarrier k when k < 32, and subcarrier k-64 otherwise. The 48 data tones sit at subcarriers -26 to +26, leaving out DC and the four pilots at ±7 and ±21. Bins outside ±26 and the DC bin are zero. The rate code of the first transfer decides the shape of the whole symbol. The finished symbol appears on a single wide ready/valid output, and it stays there until the inverse FFT takes it.

Top module: `ofdm_subcarrier_mapper`

## Requirements
- R1: After a synchronous active-high reset, out_valid is 0 and in_ready is 1.
- R2: Rate code 0 is BPSK and needs 1 transfer per symbol. Code 1 is QPSK and needs 2. Code 2 is 16-QAM and needs 4. Code 3 behaves as code 0. out_valid rises in the cycle after the transfer that completes the symbol.
- R3: Bin k carries subcarrier k for k < 32 and subcarrier k-64 otherwise. Subcarriers -21, -7 and +7 carry 0x7FFF + j0. Subcarrier +21 carries 0x8000 + j0.
- R4: The DC bin and every subcarrier with magnitude above 26 carry 0 + j0.
- R5: Data tones are numbered 0 to 47 in ascending subcarrier order from -26 to +26, leaving out DC and the pilots. With B bits per point and P = 48/B points per transfer, transfer f of a symbol fills data indices f*P to f*P+P-1. Point j of a transfer uses input bits j*B upward.
- R6: In BPSK, bit value 0 gives real 0x8000 and bit value 1 gives real 0x7FFF. The imaginary part is 0.
- R7: In QPSK, bit 2j sets the real part and bit 2j+1 sets the imaginary part. A 0 gives 0xA57E and a 1 gives 0x5A82.
- R8: In 16-QAM, bits (4j, 4j+1) set the real part and bits (4j+2, 4j+3) set the imaginary part. Each pair is read as (first, second) and maps as follows: 00 to 0x8692, 01 to 0xD786, 11 to 0x287A, 10 to 0x796E.
- R9: A transfer that arrives part-way through a symbol with a rate code that decodes differently is accepted and then discarded. It leaves the symbol under construction unchanged.
- R10: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_tones does not change.
- R11: in_ready is 0 exactly when out_valid is 1 and out_ready is 0. When out_ready is held at 1, 16-QAM transfers are taken every cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input transfer offered |
| in_ready | output | 1 | Mapper can take a transfer |
| in_rate | input | 2 | Rate code of the transfer |
| in_bits | input | 48 | Data bits of the transfer |
| out_valid | output | 1 | Complete symbol present |
| out_ready | input | 1 | Inverse FFT takes the symbol |
| out_tones | output | 2048 | 64 tones; tone k at bits [32k+31:32k], real part in the upper half |

## Verification
The assertions rely on the consumer following ready/valid rules. They also rely on out_ready being a plain input that does not depend on out_valid in the same cycle, so the hold and stall properties apply to every cycle. The stimulus meets these conditions: it changes in_valid, in_rate and in_bits only at the falling clock edge, and it sets out_ready from a free-running pattern in the monitor. After each handshake the input is held or dropped only at the falling edge. The pilot and null-tone properties look only at cycles where out_valid is 1, because tone contents outside those cycles have no meaning.

// File: rtl/ofdm_map_pkg.sv
package ofdm_map_pkg;

    localparam int SAMP_W     = 16;
    localparam int TONE_W     = 2 * SAMP_W;
    localparam int NUM_TONES  = 64;
    localparam int HALF_TONES = NUM_TONES / 2;
    localparam int FRAME_BITS = 48;
    localparam int NUM_DATA   = 48;
    localparam int EDGE_SUB   = 26;
    localparam int PILOT_IN   = 7;
    localparam int PILOT_OUT  = 21;
    localparam int QPSK_PTS   = FRAME_BITS / 2;
    localparam int QAM_PTS    = FRAME_BITS / 4;
    localparam int MAX_FRAMES = 4;
    localparam int FCNT_W     = $clog2(MAX_FRAMES);

    localparam logic [SAMP_W-1:0] Q_PLUS_ONE  = 16'h7FFF;
    localparam logic [SAMP_W-1:0] Q_MINUS_ONE = 16'h8000;
    localparam logic [SAMP_W-1:0] Q_QPSK_POS  = 16'h5A82;
    localparam logic [SAMP_W-1:0] Q_QPSK_NEG  = 16'hA57E;
    localparam logic [SAMP_W-1:0] Q_QAM_P3    = 16'h796E;
    localparam logic [SAMP_W-1:0] Q_QAM_P1    = 16'h287A;
    localparam logic [SAMP_W-1:0] Q_QAM_N1    = 16'hD786;
    localparam logic [SAMP_W-1:0] Q_QAM_N3    = 16'h8692;

    typedef enum logic [1:0] {
        MOD_BPSK  = 2'd0,
        MOD_QPSK  = 2'd1,
        MOD_QAM16 = 2'd2
    } mod_e;

    typedef struct packed {
        logic [SAMP_W-1:0] re;
        logic [SAMP_W-1:0] im;
    } cplx_t;

    function automatic mod_e decode_rate(input logic [1:0] code);
        case (code)
            2'd1:    return MOD_QPSK;
            2'd2:    return MOD_QAM16;
            default: return MOD_BPSK;
        endcase
    endfunction

    function automatic logic [FCNT_W:0] frames_needed(input mod_e m);
        case (m)
            MOD_QPSK:  return (FCNT_W+1)'(2);
            MOD_QAM16: return (FCNT_W+1)'(4);
            default:   return (FCNT_W+1)'(1);
        endcase
    endfunction

    function automatic cplx_t map_bpsk(input logic b);
        cplx_t p;
        p.re = b ? Q_PLUS_ONE : Q_MINUS_ONE;
        p.im = '0;
        return p;
    endfunction

    function automatic cplx_t map_qpsk(input logic [1:0] b);
        cplx_t p;
        p.re = b[0] ? Q_QPSK_POS : Q_QPSK_NEG;
        p.im = b[1] ? Q_QPSK_POS : Q_QPSK_NEG;
        return p;
    endfunction

    // Gray-coded level for one axis: (first, second) bit pair
    function automatic logic [SAMP_W-1:0] qam_level(input logic first, input logic second);
        case ({first, second})
            2'b00:   return Q_QAM_N3;
            2'b01:   return Q_QAM_N1;
            2'b11:   return Q_QAM_P1;
            default: return Q_QAM_P3;
        endcase
    endfunction

    function automatic cplx_t map_qam16(input logic [3:0] b);
        cplx_t p;
        p.re = qam_level(b[0], b[1]);
        p.im = qam_level(b[2], b[3]);
        return p;
    endfunction

    function automatic int bin_to_sub(input int k);
        return (k < HALF_TONES) ? k : k - NUM_TONES;
    endfunction

    function automatic bit is_pilot_sub(input int s);
        return (s == PILOT_IN) || (s == -PILOT_IN) ||
               (s == PILOT_OUT) || (s == -PILOT_OUT);
    endfunction

    function automatic bit is_data_sub(input int s);
        return (s != 0) && (s >= -EDGE_SUB) && (s <= EDGE_SUB) && !is_pilot_sub(s);
    endfunction

    function automatic int data_index_of(input int s);
        int idx;
        idx = 0;
        for (int t = -EDGE_SUB; t < s; t++)
            if (is_data_sub(t)) idx++;
        return idx;
    endfunction

    function automatic cplx_t pilot_value(input int s);
        cplx_t p;
        p.re = (s == PILOT_OUT) ? Q_MINUS_ONE : Q_PLUS_ONE;
        p.im = '0;
        return p;
    endfunction

endpackage

// File: rtl/ofdm_point_mapper.sv
module ofdm_point_mapper
    import ofdm_map_pkg::*;
(
    input  logic [FRAME_BITS-1:0] bits,
    output cplx_t                 bpsk_pts [FRAME_BITS],
    output cplx_t                 qpsk_pts [QPSK_PTS],
    output cplx_t                 qam_pts  [QAM_PTS]
);

    for (genvar j = 0; j < FRAME_BITS; j++) begin : g_bpsk
        assign bpsk_pts[j] = map_bpsk(bits[j]);
    end

    for (genvar j = 0; j < QPSK_PTS; j++) begin : g_qpsk
        assign qpsk_pts[j] = map_qpsk(bits[2*j +: 2]);
    end

    for (genvar j = 0; j < QAM_PTS; j++) begin : g_qam
        assign qam_pts[j] = map_qam16(bits[4*j +: 4]);
    end

endmodule

// File: rtl/ofdm_map_ctrl.sv
module ofdm_map_ctrl
    import ofdm_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_rate,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              out_valid,
    output logic              wr_en,
    output logic [FCNT_W-1:0] wr_frame,
    output mod_e              wr_mod
);

    logic              full_q;
    logic              busy_q;
    logic [FCNT_W-1:0] cnt_q;
    mod_e              mod_q;
    mod_e              in_mod;
    logic              take;
    logic              starting;
    logic              matching;
    logic              last;
    logic [FCNT_W:0]   need;

    assign in_mod   = decode_rate(in_rate);
    assign in_ready = !full_q || out_ready;
    assign take     = in_valid && in_ready;
    assign starting = take && !busy_q;
    assign matching = take && busy_q && (in_mod == mod_q);
    assign wr_en    = starting || matching;
    assign wr_mod   = busy_q ? mod_q : in_mod;
    assign wr_frame = busy_q ? cnt_q : '0;
    assign need     = frames_needed(wr_mod);
    assign last     = wr_en && ({1'b0, wr_frame} == need - 1'b1);
    assign out_valid = full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            mod_q  <= MOD_BPSK;
        end else begin
            if (full_q && out_ready) full_q <= 1'b0;
            if (last)                full_q <= 1'b1;
            if (wr_en) begin
                if (last) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else begin
                    busy_q <= 1'b1;
                    cnt_q  <= wr_frame + 1'b1;
                end
            end
            if (starting) mod_q <= in_mod;
        end
    end

endmodule

// File: rtl/ofdm_data_store.sv
module ofdm_data_store
    import ofdm_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [FCNT_W-1:0] wr_frame,
    input  mod_e              wr_mod,
    input  cplx_t             bpsk_pts [FRAME_BITS],
    input  cplx_t             qpsk_pts [QPSK_PTS],
    input  cplx_t             qam_pts  [QAM_PTS],
    output cplx_t             data_q   [NUM_DATA]
);

    for (genvar d = 0; d < NUM_DATA; d++) begin : g_slot
        localparam logic [FCNT_W-1:0] QPSK_F = FCNT_W'(d / QPSK_PTS);
        localparam logic [FCNT_W-1:0] QAM_F  = FCNT_W'(d / QAM_PTS);
        localparam int                QPSK_J = d % QPSK_PTS;
        localparam int                QAM_J  = d % QAM_PTS;

        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[d] <= '0;
            end else if (wr_en) begin
                case (wr_mod)
                    MOD_QPSK:  if (wr_frame == QPSK_F) data_q[d] <= qpsk_pts[QPSK_J];
                    MOD_QAM16: if (wr_frame == QAM_F)  data_q[d] <= qam_pts[QAM_J];
                    default:   data_q[d] <= bpsk_pts[d];
                endcase
            end
        end
    end

endmodule

// File: rtl/ofdm_tone_placer.sv
module ofdm_tone_placer
    import ofdm_map_pkg::*;
(
    input  cplx_t data_q [NUM_DATA],
    output cplx_t tones  [NUM_TONES]
);

    for (genvar k = 0; k < NUM_TONES; k++) begin : g_bin
        localparam int SUB = bin_to_sub(k);
        if (is_data_sub(SUB)) begin : g_data
            assign tones[k] = data_q[data_index_of(SUB)];
        end else if (is_pilot_sub(SUB)) begin : g_pilot
            assign tones[k] = pilot_value(SUB);
        end else begin : g_null
            assign tones[k] = '0;
        end
    end

endmodule

// File: rtl/ofdm_subcarrier_mapper.sv
module ofdm_subcarrier_mapper
    import ofdm_map_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [1:0]                  in_rate,
    input  logic [FRAME_BITS-1:0]       in_bits,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [NUM_TONES*TONE_W-1:0] out_tones
);

    cplx_t             bpsk_pts [FRAME_BITS];
    cplx_t             qpsk_pts [QPSK_PTS];
    cplx_t             qam_pts  [QAM_PTS];
    cplx_t             data_q   [NUM_DATA];
    cplx_t             tones    [NUM_TONES];
    logic              wr_en;
    logic [FCNT_W-1:0] wr_frame;
    mod_e              wr_mod;

    ofdm_map_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_rate   (in_rate),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .wr_en     (wr_en),
        .wr_frame  (wr_frame),
        .wr_mod    (wr_mod)
    );

    ofdm_point_mapper u_points (
        .bits     (in_bits),
        .bpsk_pts (bpsk_pts),
        .qpsk_pts (qpsk_pts),
        .qam_pts  (qam_pts)
    );

    ofdm_data_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_frame (wr_frame),
        .wr_mod   (wr_mod),
        .bpsk_pts (bpsk_pts),
        .qpsk_pts (qpsk_pts),
        .qam_pts  (qam_pts),
        .data_q   (data_q)
    );

    ofdm_tone_placer u_place (
        .data_q (data_q),
        .tones  (tones)
    );

    for (genvar k = 0; k < NUM_TONES; k++) begin : g_flat
        assign out_tones[k*TONE_W +: TONE_W] = tones[k];
    end

endmodule

// File: rtl/ofdm_map_checker.sv
module ofdm_map_checker
    import ofdm_map_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic                        out_ready,
    input logic [NUM_TONES*TONE_W-1:0] out_tones
);

    localparam int BIN_NEG_OUT = NUM_TONES - PILOT_OUT;
    localparam int BIN_NEG_IN  = NUM_TONES - PILOT_IN;

    logic pilots_ok;
    logic nulls_ok;

    always_comb begin
        pilots_ok = (out_tones[PILOT_IN*TONE_W    +: TONE_W] == {Q_PLUS_ONE, 16'h0000}) &&
                    (out_tones[BIN_NEG_IN*TONE_W  +: TONE_W] == {Q_PLUS_ONE, 16'h0000}) &&
                    (out_tones[BIN_NEG_OUT*TONE_W +: TONE_W] == {Q_PLUS_ONE, 16'h0000}) &&
                    (out_tones[PILOT_OUT*TONE_W   +: TONE_W] == {Q_MINUS_ONE, 16'h0000});
    end

    always_comb begin
        nulls_ok = (out_tones[0 +: TONE_W] == '0);
        for (int k = EDGE_SUB + 1; k < NUM_TONES - EDGE_SUB; k++)
            if (out_tones[k*TONE_W +: TONE_W] != '0) nulls_ok = 1'b0;
    end

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tones)));

    assert_stall_input_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    assert_ready_when_empty_R11: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> in_ready);

    assert_pilot_values_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> pilots_ok);

    assert_null_tones_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> nulls_ok);

endmodule

bind ofdm_subcarrier_mapper ofdm_map_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tones (out_tones)
);

// File: tb/tb_ofdm_subcarrier_mapper.sv
module tb_ofdm_subcarrier_mapper;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [1:0]    in_rate = 2'd0;
    logic [47:0]   in_bits = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2047:0] out_tones;

    int checks = 0;
    int fails  = 0;
    int stall_cnt = 0;
    int got_syms = 0;
    int sent_syms = 0;
    bit stall_mode = 1'b0;
    bit done = 1'b0;

    logic [2047:0] exp_q [$];
    logic [1:0]    rate_q [$];

    always #2 clk = ~clk;

    ofdm_subcarrier_mapper dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_rate   (in_rate),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_tones (out_tones)
    );

    function automatic logic [15:0] lvl16(input logic a, input logic b);
        case ({a, b})
            2'b00:   return 16'h8692;
            2'b01:   return 16'hD786;
            2'b11:   return 16'h287A;
            default: return 16'h796E;
        endcase
    endfunction

    // Expected symbol from R3..R8
    function automatic logic [2047:0] build_exp(input logic [1:0] rate, input logic [191:0] fr);
        logic [2047:0] e;
        int bps;
        int pts;
        bps = (rate == 2'd1) ? 2 : (rate == 2'd2) ? 4 : 1;
        pts = 48 / bps;
        for (int k = 0; k < 64; k++) begin
            int s;
            logic [31:0] t;
            s = (k < 32) ? k : k - 64;
            if (s == -21 || s == -7 || s == 7) t = 32'h7FFF_0000;
            else if (s == 21) t = 32'h8000_0000;
            else if (s == 0 || s > 26 || s < -26) t = '0;
            else begin
                int d;
                int base;
                logic [3:0] b;
                if (s < 0) d = s + 26 - int'(s > -21) - int'(s > -7);
                else       d = 23 + s - int'(s > 7) - int'(s > 21);
                base = (d / pts) * 48 + (d % pts) * bps;
                b = fr[base +: 4];
                case (rate)
                    2'd1:    t = {b[0] ? 16'h5A82 : 16'hA57E, b[1] ? 16'h5A82 : 16'hA57E};
                    2'd2:    t = {lvl16(b[0], b[1]), lvl16(b[2], b[3])};
                    default: t = {b[0] ? 16'h7FFF : 16'h8000, 16'h0000};
                endcase
            end
            e[k*32 +: 32] = t;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic send_frame(input logic [1:0] rate, input logic [47:0] bits);
        @(negedge clk);
        in_valid = 1'b1;
        in_rate  = rate;
        in_bits  = bits;
        #1;
        while (!in_ready) begin
            stall_cnt++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_symbol(input logic [1:0] rate, input logic [191:0] fr);
        int n;
        n = (rate == 2'd1) ? 2 : (rate == 2'd2) ? 4 : 1;
        exp_q.push_back(build_exp(rate, fr));
        rate_q.push_back(rate);
        sent_syms++;
        for (int i = 0; i < n; i++) send_frame(rate, fr[i*48 +: 48]);
    endtask

    // Monitor / scoreboard
    initial begin
        logic [2047:0] held;
        bit held_pending;
        held_pending = 1'b0;
        forever begin
            @(negedge clk);
            out_ready = stall_mode ? (($urandom % 3) == 0) : 1'b1;
            #1;
            if (!rst) begin
                if (held_pending) begin
                    check(out_valid && (out_tones == held), "R10", "symbol held while stalled",
                          {63'd0, out_valid}, 64'd1);
                    held_pending = 1'b0;
                end
                if (out_valid && !out_ready) begin
                    check(!in_ready, "R11", "in_ready during stall", {63'd0, in_ready}, 64'd0);
                    held = out_tones;
                    held_pending = 1'b1;
                end
                if (out_valid && out_ready) begin
                    got_syms++;
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R2", "unexpected symbol", 64'd1, 64'd0);
                    end else begin
                        logic [2047:0] e;
                        logic [1:0] r;
                        e = exp_q.pop_front();
                        r = rate_q.pop_front();
                        checks++;
                        if (e != out_tones) begin
                            fails++;
                            for (int k = 0; k < 64; k++) begin
                                if (e[k*32 +: 32] != out_tones[k*32 +: 32]) begin
                                    $display("FAIL R3/R4/R5/R%0s rate=%0d bin %0d actual=%h expected=%h",
                                             (r == 2'd1) ? "7" : (r == 2'd2) ? "8" : "6",
                                             r, k, out_tones[k*32 +: 32], e[k*32 +: 32]);
                                    break;
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", got_syms, sent_syms);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", {63'd0, out_valid}, 64'd0);
        check(in_ready == 1'b1, "R1", "in_ready after reset", {63'd0, in_ready}, 64'd1);

        // R2, R6: BPSK single transfer, code 0
        send_symbol(2'd0, {144'd0, 48'hA5A5_0F0F_1234});
        idle();
        // R2: out_valid exactly one cycle after the completing transfer
        #1;
        check(out_valid == 1'b1, "R2", "out_valid after last BPSK transfer", {63'd0, out_valid}, 64'd1);
        send_symbol(2'd0, {144'd0, 48'h0});
        send_symbol(2'd0, {144'd0, 48'hFFFF_FFFF_FFFF});
        idle();
        // R2: code 3 treated as BPSK
        send_symbol(2'd3, {144'd0, 48'h5A5A_C3C3_9669});
        idle();

        // R7: QPSK
        send_symbol(2'd1, {96'd0, 48'h0123_4567_89AB, 48'hFEDC_BA98_7654});
        send_symbol(2'd1, {96'd0, 48'hAAAA_5555_F0F0, 48'h3333_CCCC_0F0F});
        idle();

        // R8: 16-QAM
        send_symbol(2'd2, {48'h0123_4567_89AB, 48'hCDEF_FEDC_BA98, 48'h7654_3210_0F1E, 48'h2D3C_4B5A_6978});
        idle();

        // R9: mismatched transfer mid-symbol is discarded
        exp_q.push_back(build_exp(2'd1, {96'd0, 48'h1111_2222_3333, 48'hDEAD_BEEF_CAFE}));
        rate_q.push_back(2'd1);
        sent_syms++;
        send_frame(2'd1, 48'hDEAD_BEEF_CAFE);
        send_frame(2'd2, 48'hFFFF_0000_FFFF);
        send_frame(2'd0, 48'h0000_FFFF_0000);
        send_frame(2'd1, 48'h1111_2222_3333);
        idle();

        // R10: consumer stalls randomly
        stall_mode = 1'b1;
        for (int i = 0; i < 12; i++) begin
            logic [191:0] fr;
            fr = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            send_symbol(2'(i % 3), fr);
        end
        idle();
        repeat (40) @(negedge clk);
        stall_mode = 1'b0;
        repeat (4) @(negedge clk);

        // R11: back-to-back 16-QAM with no stall
        stall_cnt = 0;
        for (int i = 0; i < 4; i++) begin
            logic [191:0] fr;
            fr = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            send_symbol(2'd2, fr);
        end
        idle();
        check(stall_cnt == 0, "R11", "stalls at full rate", 64'(stall_cnt), 64'd0);

        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R2", "symbols left undelivered", 64'(exp_q.size()), 64'd0);
        check(got_syms == sent_syms, "R2", "symbol count", 64'(got_syms), 64'(sent_syms));
        finish_run();
    end

endmodule